// File: doc/BRIEF.md
# Audio Control Packet Builder

This block produces the ancillary audio control packet for one audio group. The packet goes into the horizontal blanking of the luma channel, once in each field, on a switching line programmed separately for each field. A configuration set supplies the fields: an enable bit, the group number, the asynchronous flag, the active-channel bits, two 26-bit processing-delay values and 18 reserved bits. The video timing side supplies the current line number, the field flag and a strobe that marks a free insertion slot. The block answers with a 10-bit word stream and a valid flag, and a downstream multiplexer merges that stream into the video.

A packet holds 17 words, one per clock with no gaps. It starts with the three-word ancillary flag (000h, 3FFh, 3FFh). Next come the group identifier, a block number of 200h and a data count of 20Ah. Then come ten user words: rate, active channels, three words for the first delay, three words for the second delay and two reserved words. A checksum word ends the packet. The configuration is captured when a packet starts, so writes made during a packet only affect the next one.

The control is a two-state machine. `IDLE` waits for an accepted slot; the `ACCEPT` transition takes it to `SEND` and captures the configuration. In `SEND`, the `STEP` transition advances the word index each cycle, and the `DONE` transition returns to `IDLE` after the checksum word.

Top module: `acp_builder`

## Requirements
- R1: While reset is held and after it is released, with no strobe yet seen, `anc_valid_o` is 0 and `anc_word_o` is 000h.
- R2: An accepted strobe in cycle n makes `anc_valid_o` high from cycle n+1 through cycle n+17 with no gap, and low in cycle n+18.
- R3: Words 0..2 are 000h, 3FFh, 3FFh; word 4 (block number) is 200h; word 5 (data count) is 20Ah.
- R4: Word 3 is the group identifier: group select 0, 1, 2, 3 give 1E3h, 2E2h, 2E1h, 1E0h.
- R5: Word 6 (rate) has payload bit 0 equal to the asynchronous flag (1 = non-synchronous) and other payload bits 0. Word 7 carries the 4 active-channel bits in payload bits 3:0. In both, bit 9 is the inverse of bit 8.
- R6: Words 8..10 carry the first delay and words 11..13 the second delay. Each delay is zero-extended to 27 bits and cut into 9-bit payloads, least significant first, with bit 9 = NOT bit 8.
- R7: Words 14 and 15 carry reserved bits 8:0 and 17:9 as payloads, with bit 9 = NOT bit 8.
- R8: Word 16 is the checksum. Its payload is the sum modulo 512 of the 9-bit payloads of words 3..15, and bit 9 is the inverse of bit 8.
- R9: With the enable bit low, a strobe starts no packet.
- R10: A strobe starts a packet only when the line number equals the field-1 line (field flag 0) or the field-2 line (field flag 1).
- R11: At most one packet is sent per field. A further strobe on the matching line is ignored until the field flag changes value.
- R12: Configuration changes made while a packet is being sent do not alter that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acp_en_i | input | 1 | Packet enable |
| grp_sel_i | input | 2 | Audio group, 0..3 for groups 1..4 |
| async_i | input | 1 | Asynchronous flag (1 = non-synchronous) |
| act_i | input | 4 | Active-channel bits |
| delay12_i | input | 26 | Delay value for the first channel pair |
| delay34_i | input | 26 | Delay value for the second channel pair |
| rsv_i | input | 18 | Reserved bits |
| line_f1_i | input | 13 | Switching line for field 1 |
| line_f2_i | input | 13 | Switching line for field 2 |
| line_i | input | 13 | Current line number |
| field_i | input | 1 | Field flag, 0 = field 1, 1 = field 2 |
| slot_i | input | 1 | Insertion-slot strobe |
| anc_word_o | output | 10 | Packet word |
| anc_valid_o | output | 1 | Packet word valid |

## Verification
Word k of a packet shows on the outputs in the (k+1)-th cycle after the cycle in which the strobe was sampled high. The checksum is the 17th word, and valid drops in the 18th cycle. The bench drives the strobe for one cycle between falling edges, then samples at each later falling edge, so the sample for word k lands k+1 rising edges after the strobe. Cases that must produce no packet are watched for 20 cycles, which is longer than that latency. The mid-packet configuration change is written after word 2 has been sampled.

// File: rtl/acp_pkg.sv
package acp_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_SEND
    } acp_state_t;

    // Ancillary word from a 9-bit payload: top bit is the inverse of bit 8
    function automatic logic [9:0] acp_word(input logic [8:0] pay);
        return {~pay[8], pay};
    endfunction

    // Group identifier payloads (bits 8:0) for groups 1..4
    function automatic logic [8:0] acp_did_pay(input logic [1:0] grp);
        logic [8:0] p;
        unique case (grp)
            2'd0: p = 9'h1E3;
            2'd1: p = 9'h0E2;
            2'd2: p = 9'h0E1;
            2'd3: p = 9'h1E0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/acp_trigger.sv
module acp_trigger #(
    parameter int LINE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              slot_i,
    input  logic              field_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [LINE_W-1:0] line_f1_i,
    input  logic [LINE_W-1:0] line_f2_i,
    input  logic              busy_i,
    output logic              start_o
);

    logic field_q;
    logic sent_q;
    logic field_chg;
    logic sent_eff;
    logic line_hit;

    assign field_chg = field_i != field_q;
    assign sent_eff  = sent_q & ~field_chg;
    assign line_hit  = line_i == (field_i ? line_f2_i : line_f1_i);
    assign start_o   = en_i & slot_i & line_hit & ~sent_eff & ~busy_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_q <= 1'b0;
            sent_q  <= 1'b0;
        end else begin
            field_q <= field_i;
            sent_q  <= start_o | sent_eff;
        end
    end

    AST_ONCE_PER_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start_o) && $past(rst_n) && field_i == $past(field_i)) |-> !start_o); // R11

endmodule

// File: rtl/acp_sequencer.sv
module acp_sequencer
    import acp_pkg::*;
#(
    parameter int N_WORDS = 17,
    localparam int IDX_W  = $clog2(N_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_WORDS - 1);

    acp_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin          // ACCEPT
                    state_d = ST_SEND;
                    idx_d   = '0;
                end
            end
            ST_SEND: begin
                if (idx_q == LAST) begin    // DONE
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end else begin              // STEP
                    idx_d = idx_q + 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        valid_o = state_q == ST_SEND;
        idx_o   = idx_q;
    end

    AST_RUN_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && idx_o != LAST) |=> (valid_o && idx_o == $past(idx_o) + 1'b1)); // R2
    AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && idx_o == LAST) |=> !valid_o); // R2

endmodule

// File: rtl/acp_formatter.sv
module acp_formatter
    import acp_pkg::*;
#(
    parameter int DELAY_W = 26,
    parameter int RSV_W   = 18,
    parameter int ACT_W   = 4,
    parameter int PAY_W   = 9,
    parameter int IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture_i,
    input  logic [1:0]         grp_i,
    input  logic               async_i,
    input  logic [ACT_W-1:0]   act_i,
    input  logic [DELAY_W-1:0] d12_i,
    input  logic [DELAY_W-1:0] d34_i,
    input  logic [RSV_W-1:0]   rsv_i,
    input  logic               valid_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [9:0]         word_o
);

    localparam int DEL_WORDS = (DELAY_W + PAY_W - 1) / PAY_W;
    localparam int RSV_WORDS = (RSV_W + PAY_W - 1) / PAY_W;
    localparam int UDW       = 2 + 2 * DEL_WORDS + RSV_WORDS;
    localparam int IDX_DID   = 3;
    localparam int IDX_DBN   = 4;
    localparam int IDX_DC    = 5;
    localparam int IDX_RATE  = 6;
    localparam int IDX_ACT   = 7;
    localparam int IDX_D12   = 8;
    localparam int IDX_D34   = IDX_D12 + DEL_WORDS;
    localparam int IDX_RSV   = IDX_D34 + DEL_WORDS;
    localparam int IDX_CS    = IDX_RSV + RSV_WORDS;
    localparam logic [7:0] UDW8   = 8'(UDW);
    localparam logic [8:0] DC_PAY = {^UDW8, UDW8};

    logic [1:0]         snap_grp;
    logic               snap_async;
    logic [ACT_W-1:0]   snap_act;
    logic [DELAY_W-1:0] snap_d12;
    logic [DELAY_W-1:0] snap_d34;
    logic [RSV_W-1:0]   snap_rsv;
    logic [8:0]         csum_q;

    logic [DEL_WORDS*PAY_W-1:0] d12_pad, d34_pad;
    logic [RSV_WORDS*PAY_W-1:0] rsv_pad;
    logic [PAY_W-1:0] d12_chunk [DEL_WORDS];
    logic [PAY_W-1:0] d34_chunk [DEL_WORDS];
    logic [PAY_W-1:0] rsv_chunk [RSV_WORDS];

    assign d12_pad = (DEL_WORDS*PAY_W)'(snap_d12);
    assign d34_pad = (DEL_WORDS*PAY_W)'(snap_d34);
    assign rsv_pad = (RSV_WORDS*PAY_W)'(snap_rsv);

    for (genvar g = 0; g < DEL_WORDS; g++) begin : g_del
        assign d12_chunk[g] = d12_pad[g*PAY_W +: PAY_W];
        assign d34_chunk[g] = d34_pad[g*PAY_W +: PAY_W];
    end
    for (genvar g = 0; g < RSV_WORDS; g++) begin : g_rsv
        assign rsv_chunk[g] = rsv_pad[g*PAY_W +: PAY_W];
    end

    // Configuration snapshot, taken when a packet is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_grp   <= '0;
            snap_async <= 1'b0;
            snap_act   <= '0;
            snap_d12   <= '0;
            snap_d34   <= '0;
            snap_rsv   <= '0;
        end else if (capture_i) begin
            snap_grp   <= grp_i;
            snap_async <= async_i;
            snap_act   <= act_i;
            snap_d12   <= d12_i;
            snap_d34   <= d34_i;
            snap_rsv   <= rsv_i;
        end
    end

    logic [8:0] pay;
    logic       in_sum;
    int         idx;

    always_comb begin
        idx    = int'(idx_i);
        pay    = '0;
        in_sum = valid_i && idx >= IDX_DID && idx < IDX_CS;
        if (idx == IDX_DID)       pay = acp_did_pay(snap_grp);
        else if (idx == IDX_DBN)  pay = 9'h000;
        else if (idx == IDX_DC)   pay = DC_PAY;
        else if (idx == IDX_RATE) pay = 9'(snap_async);
        else if (idx == IDX_ACT)  pay = 9'(snap_act);
        else if (idx == IDX_CS)   pay = csum_q;
        for (int k = 0; k < DEL_WORDS; k++) begin
            if (idx == IDX_D12 + k) pay = 9'(d12_chunk[k]);
            if (idx == IDX_D34 + k) pay = 9'(d34_chunk[k]);
        end
        for (int k = 0; k < RSV_WORDS; k++) begin
            if (idx == IDX_RSV + k) pay = 9'(rsv_chunk[k]);
        end
    end

    always_comb begin
        if (!valid_i)                word_o = 10'h000;
        else if (idx == 0)           word_o = 10'h000;
        else if (idx < IDX_DID)      word_o = 10'h3FF;
        else                         word_o = acp_word(pay);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        csum_q <= '0;
        else if (capture_i) csum_q <= '0;
        else if (in_sum)   csum_q <= csum_q + word_o[8:0];
    end

    AST_WORD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && idx >= IDX_DID) |-> (word_o[9] == ~word_o[8])); // R6
    AST_SNAPSHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && $past(valid_i) && !capture_i) |-> ($stable(snap_d12) && $stable(snap_grp))); // R12

endmodule

// File: rtl/acp_builder.sv
module acp_builder #(
    parameter int LINE_W  = 13,
    parameter int DELAY_W = 26,
    parameter int RSV_W   = 18,
    parameter int ACT_W   = 4,
    parameter int PAY_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acp_en_i,
    input  logic [1:0]         grp_sel_i,
    input  logic               async_i,
    input  logic [ACT_W-1:0]   act_i,
    input  logic [DELAY_W-1:0] delay12_i,
    input  logic [DELAY_W-1:0] delay34_i,
    input  logic [RSV_W-1:0]   rsv_i,
    input  logic [LINE_W-1:0]  line_f1_i,
    input  logic [LINE_W-1:0]  line_f2_i,
    input  logic [LINE_W-1:0]  line_i,
    input  logic               field_i,
    input  logic               slot_i,
    output logic [9:0]         anc_word_o,
    output logic               anc_valid_o
);

    localparam int DEL_WORDS = (DELAY_W + PAY_W - 1) / PAY_W;
    localparam int RSV_WORDS = (RSV_W + PAY_W - 1) / PAY_W;
    localparam int N_WORDS   = 3 + 3 + 2 + 2 * DEL_WORDS + RSV_WORDS + 1;
    localparam int IDX_W     = $clog2(N_WORDS);

    logic             start;
    logic             valid;
    logic [IDX_W-1:0] idx;

    acp_trigger #(.LINE_W(LINE_W)) u_trigger (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (acp_en_i),
        .slot_i    (slot_i),
        .field_i   (field_i),
        .line_i    (line_i),
        .line_f1_i (line_f1_i),
        .line_f2_i (line_f2_i),
        .busy_i    (valid),
        .start_o   (start)
    );

    acp_sequencer #(.N_WORDS(N_WORDS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .valid_o (valid),
        .idx_o   (idx)
    );

    acp_formatter #(
        .DELAY_W (DELAY_W),
        .RSV_W   (RSV_W),
        .ACT_W   (ACT_W),
        .PAY_W   (PAY_W),
        .IDX_W   (IDX_W)
    ) u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (start),
        .grp_i     (grp_sel_i),
        .async_i   (async_i),
        .act_i     (act_i),
        .d12_i     (delay12_i),
        .d34_i     (delay34_i),
        .rsv_i     (rsv_i),
        .valid_i   (valid),
        .idx_i     (idx),
        .word_o    (anc_word_o)
    );

    assign anc_valid_o = valid;

    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(anc_valid_o) |-> $past(acp_en_i && slot_i)); // R9
    AST_LINE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(anc_valid_o) |-> ($past(line_i) == ($past(field_i) ? $past(line_f2_i) : $past(line_f1_i)))); // R10
    AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(anc_valid_o) |-> anc_word_o == 10'h000); // R3

endmodule

// File: tb/test_acp_builder.sv
module test_acp_builder;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 17;

    typedef logic [9:0] pkt_t [NW];

    typedef struct packed {
        logic [1:0]  grp;
        logic        async_f;
        logic [3:0]  act;
        logic        fld;
        logic [25:0] d12;
        logic [25:0] d34;
        logic [17:0] rsv;
        logic [9:0]  did;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'd0, 1'b0, 4'hF, 1'b0, 26'h0000001, 26'h3FFFFFF, 18'h3FFFF, 10'h1E3},
        '{2'd1, 1'b1, 4'h5, 1'b1, 26'h2AAAAAA, 26'h1555555, 18'h00000, 10'h2E2},
        '{2'd2, 1'b0, 4'h0, 1'b0, 26'h0123456, 26'h0000000, 18'h2A5A5, 10'h2E1},
        '{2'd3, 1'b1, 4'hA, 1'b1, 26'h3FFFFFF, 26'h0200100, 18'h1FFFF, 10'h1E0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic [1:0]  grp = '0;
    logic        async_f = 1'b0;
    logic [3:0]  act = '0;
    logic [25:0] d12 = '0;
    logic [25:0] d34 = '0;
    logic [17:0] rsv = '0;
    logic [12:0] lf1 = 13'd20;
    logic [12:0] lf2 = 13'd583;
    logic [12:0] line = '0;
    logic        field = 1'b0;
    logic        slot = 1'b0;
    logic [9:0]  word;
    logic        valid;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acp_builder i_acp_builder (
        .clk (clk), .rst_n (rst_n), .acp_en_i (en), .grp_sel_i (grp),
        .async_i (async_f), .act_i (act), .delay12_i (d12), .delay34_i (d34),
        .rsv_i (rsv), .line_f1_i (lf1), .line_f2_i (lf2), .line_i (line),
        .field_i (field), .slot_i (slot), .anc_word_o (word), .anc_valid_o (valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [9:0] pw(input logic [8:0] p);
        return {~p[8], p};
    endfunction

    function automatic pkt_t build(input vec_t v);
        pkt_t w;
        logic [26:0] a = {1'b0, v.d12};
        logic [26:0] b = {1'b0, v.d34};
        logic [8:0] s = '0;
        w[0] = 10'h000; w[1] = 10'h3FF; w[2] = 10'h3FF;
        w[3] = v.did; w[4] = 10'h200; w[5] = 10'h20A;
        w[6] = pw({8'd0, v.async_f});
        w[7] = pw({5'd0, v.act});
        for (int k = 0; k < 3; k++) begin
            w[8+k]  = pw(a[9*k +: 9]);
            w[11+k] = pw(b[9*k +: 9]);
        end
        w[14] = pw(v.rsv[8:0]);
        w[15] = pw(v.rsv[17:9]);
        for (int k = 3; k < 16; k++) s = s + w[k][8:0];
        w[16] = pw(s);
        return w;
    endfunction

    function automatic string tag_of(input int k);
        if (k == 3) return "R4";
        if (k < 6) return "R3";
        if (k < 8) return "R5";
        if (k < 14) return "R6";
        if (k < 16) return "R7";
        return "R8";
    endfunction

    task automatic apply_cfg(input vec_t v);
        grp = v.grp; async_f = v.async_f; act = v.act;
        d12 = v.d12; d34 = v.d34; rsv = v.rsv;
    endtask

    // Strobe one slot, then sample every word at the following falling edges
    task automatic grab(input pkt_t exp, input bit mutate);
        @(negedge clk); slot = 1'b1;
        @(negedge clk); slot = 1'b0;
        for (int k = 0; k < NW; k++) begin
            chk(valid === 1'b1, "R2 valid during packet", 32'(valid), 32'd1);
            chk(word === exp[k], mutate ? "R12 captured config" : tag_of(k), 32'(word), 32'(exp[k]));
            if (mutate && k == 2) begin
                grp = ~grp; async_f = ~async_f; act = ~act;
                d12 = ~d12; d34 = ~d34; rsv = ~rsv;
            end
            @(negedge clk);
        end
        chk(valid === 1'b0, "R2 valid after checksum", 32'(valid), 32'd0);
    endtask

    task automatic expect_none(input string req);
        bit seen = 0;
        @(negedge clk); slot = 1'b1;
        @(negedge clk); slot = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (valid !== 1'b0) seen = 1;
            @(negedge clk);
        end
        chk(!seen, req, 32'(seen), 32'd0);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(valid === 1'b0 && word === 10'h000, "R1 in reset", 32'({valid, word}), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(valid === 1'b0 && word === 10'h000, "R1 after reset", 32'({valid, word}), 32'd0);

        // Vector walk: each entry alternates the field, re-arming the gate
        for (int i = 0; i < 4; i++) begin
            apply_cfg(VECS[i]);
            field = VECS[i].fld;
            line = VECS[i].fld ? lf2 : lf1;
            grab(build(VECS[i]), 1'b0);
        end

        // R10: wrong line in field 1, then field 2's line while in field 1
        @(negedge clk); field = 1'b0; line = lf1 + 13'd1;
        expect_none("R10 off-line strobe");
        line = lf2;
        expect_none("R10 other field line");

        // R9: enable low on the matching line
        line = lf1; en = 1'b0;
        expect_none("R9 disabled");
        en = 1'b1;
        apply_cfg(VECS[0]);
        grab(build(VECS[0]), 1'b0);

        // R11: second strobe in the same field is ignored
        expect_none("R11 second strobe same field");

        // R11 re-arm on field change, R12 mid-packet config change
        @(negedge clk); field = 1'b1; line = lf2;
        apply_cfg(VECS[2]);
        grab(build(VECS[2]), 1'b1);

        finish_up();
    end

endmodule